// File: doc/BRIEF.md
# Device Interrupt Request Controller

This block owns the interrupt request pin of a storage device on a shared host cable. It keeps one pending-interrupt flag. Command-dependent events set the flag, and host-side strobes clear it. The pin is driven only while this device is selected and the host has left interrupts enabled. At all other times the block deasserts the output enable, so the pin floats at the pad.

When the host writes the command register, the block latches the class of the new command. From then until the command ends, it applies the matching rule for raising interrupts. Programmed-I/O reads interrupt at the start of every data block. Programmed-I/O write-type commands skip the first block. DMA and non-data commands interrupt once, when the command completes.

Top module: `devirq_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, the pending flag is clear, so `irq_oe` is 0 until a set event arrives.
- R2: `irq_oe` is 1 only when an interrupt is pending, `dev_sel` is 1 and `nien` is 0. While `irq_oe` is 1, `irq_line` sits at its active level (1 with the default `ACTIVE_HIGH`=1).
- R3: When `nien` is 1 or `dev_sel` is 0, `irq_oe` is 0 whether or not an interrupt is pending. The pending flag is kept, so it shows on the pin again once the gate reopens.
- R4: Each of `sts_rd`, `cmd_wr` and `srst_set`, held high for one cycle, clears the pending flag at the next clock edge.
- R5: With a programmed-I/O read command active (`cmd_class` 2'b00), every `blk_start` pulse sets the pending flag.
- R6: With a programmed-I/O write-type command active (`cmd_class` 2'b01), the first `blk_start` after the command write sets nothing, and each later `blk_start` sets the flag.
- R7: With a DMA command active (`cmd_class` 2'b10), `blk_start` is ignored. `cmd_done` sets the flag once and ends the command, so a further `cmd_done` sets nothing.
- R8: With a non-data command active (`cmd_class` 2'b11), `cmd_done` sets the pending flag.
- R9: When a set event and a clear strobe fall in the same cycle, the pending flag ends up set.
- R10: `srst_set` ends the active command. Any `blk_start` or `cmd_done` that arrives afterwards, before the next `cmd_wr`, is ignored.
- R11: `cmd_done` during a programmed-I/O command ends that command without setting the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| cmd_wr | input | 1 | One-cycle strobe: host wrote the command register |
| cmd_class | input | 2 | Class of the command written; sampled with `cmd_wr` |
| blk_start | input | 1 | One-cycle pulse: a data block is about to be transferred |
| cmd_done | input | 1 | One-cycle pulse: the active command has completed |
| srst_set | input | 1 | One-cycle strobe: software-reset bit set by host |
| sts_rd | input | 1 | One-cycle strobe: host read the status register |
| dev_sel | input | 1 | This device is the selected one |
| nien | input | 1 | Interrupt disable bit from the control register |
| irq_line | output | 1 | Interrupt request level |
| irq_oe | output | 1 | Output enable for `irq_line`; 0 means high impedance |

## Verification
The assertions assume that every strobe and event input is a single-cycle pulse sampled on the rising clock edge. They also assume that `cmd_class` is meaningful only in a cycle where `cmd_wr` is high. The first-block check relies on a write-type command write being followed directly by a block event. That is the only ordering in which the skip rule can be observed at the next cycle. The directed tasks raise each strobe for exactly one clock, starting just after an edge, and change `dev_sel` and `nien` only between pulses.

// File: rtl/devirq_pkg.sv
package devirq_pkg;
   localparam int CLASS_W = 2;

   typedef enum logic [CLASS_W-1:0] {
      CLS_PIO_IN  = 2'b00,
      CLS_PIO_OUT = 2'b01,
      CLS_DMA     = 2'b10,
      CLS_NODATA  = 2'b11
   } cmd_class_e;

   function automatic logic is_pio(cmd_class_e c);
      return (c == CLS_PIO_IN) || (c == CLS_PIO_OUT);
   endfunction

   function automatic logic irq_on_done(cmd_class_e c);
      return (c == CLS_DMA) || (c == CLS_NODATA);
   endfunction
endpackage

// File: rtl/devirq_cmd_track.sv
module devirq_cmd_track
   import devirq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_wr,
   input  logic [CLASS_W-1:0] cmd_class,
   input  logic               srst_set,
   input  logic               blk_start,
   input  logic               cmd_done,
   output logic               set_evt
);
   logic       active_q;
   logic       first_q;
   cmd_class_e cls_q;
   logic       blk_hit;
   logic       done_hit;

   // Events are judged against the command latched before this cycle.
   always_comb begin
      blk_hit  = active_q && blk_start && is_pio(cls_q);
      done_hit = active_q && cmd_done;
      set_evt  = (blk_hit && !(cls_q == CLS_PIO_OUT && first_q)) ||
                 (done_hit && irq_on_done(cls_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         first_q  <= 1'b0;
         cls_q    <= CLS_PIO_IN;
      end else if (srst_set) begin
         active_q <= 1'b0;
         first_q  <= 1'b0;
      end else if (cmd_wr) begin
         active_q <= 1'b1;
         first_q  <= 1'b1;
         cls_q    <= cmd_class_e'(cmd_class);
      end else begin
         if (blk_hit)  first_q  <= 1'b0;
         if (done_hit) active_q <= 1'b0;
      end
   end
endmodule

// File: rtl/devirq_pend.sv
module devirq_pend #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_evt,
   output logic pend
);
   logic pend_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb pend_d = set_evt || (pend && !clr_evt);
      end else begin : g_clr_first
         always_comb pend_d = !clr_evt && (set_evt || pend);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= pend_d;
   end
endmodule

// File: rtl/devirq_pin.sv
module devirq_pin #(
   parameter bit OUT_REG     = 1'b0,
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend,
   input  logic dev_sel,
   input  logic nien,
   output logic irq_line,
   output logic irq_oe
);
   localparam logic LVL_ON  = ACTIVE_HIGH;
   localparam logic LVL_OFF = !ACTIVE_HIGH;

   logic oe_d;
   always_comb oe_d = pend && dev_sel && !nien;

   generate
      if (OUT_REG) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_oe   <= 1'b0;
               irq_line <= LVL_OFF;
            end else begin
               irq_oe   <= oe_d;
               irq_line <= oe_d ? LVL_ON : LVL_OFF;
            end
         end
      end else begin : g_comb
         always_comb begin
            irq_oe   = oe_d;
            irq_line = oe_d ? LVL_ON : LVL_OFF;
         end
      end
   endgenerate
endmodule

// File: rtl/devirq_ctrl.sv
module devirq_ctrl
   import devirq_pkg::*;
#(
   parameter int CLS_W       = 2,
   parameter bit SET_WINS    = 1'b1,
   parameter bit OUT_REG     = 1'b0,
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CLS_W-1:0] cmd_class,
   input  logic             blk_start,
   input  logic             cmd_done,
   input  logic             srst_set,
   input  logic             sts_rd,
   input  logic             dev_sel,
   input  logic             nien,
   output logic             irq_line,
   output logic             irq_oe
);
   generate
      if (CLS_W != CLASS_W) begin : g_bad_width
         $error("devirq_ctrl: CLS_W must equal the package class width");
      end
   endgenerate

   logic set_evt;
   logic clr_evt;
   logic pend;

   always_comb clr_evt = srst_set || cmd_wr || sts_rd;

   devirq_cmd_track i_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .cmd_class (cmd_class),
      .srst_set  (srst_set),
      .blk_start (blk_start),
      .cmd_done  (cmd_done),
      .set_evt   (set_evt)
   );

   devirq_pend #(.SET_WINS(SET_WINS)) i_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_evt),
      .clr_evt (clr_evt),
      .pend    (pend)
   );

   devirq_pin #(.OUT_REG(OUT_REG), .ACTIVE_HIGH(ACTIVE_HIGH)) i_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend     (pend),
      .dev_sel  (dev_sel),
      .nien     (nien),
      .irq_line (irq_line),
      .irq_oe   (irq_oe)
   );
endmodule

// File: rtl/devirq_ctrl_chk.sv
module devirq_ctrl_chk #(
   parameter bit SET_WINS    = 1'b1,
   parameter bit OUT_REG     = 1'b0,
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wr,
   input logic [1:0] cmd_class,
   input logic       blk_start,
   input logic       srst_set,
   input logic       sts_rd,
   input logic       dev_sel,
   input logic       nien,
   input logic       set_evt,
   input logic       pend,
   input logic       irq_line,
   input logic       irq_oe
);
   // R4: a clear strobe with no set event empties the flag
   a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts_rd || cmd_wr || srst_set) && !set_evt) |=> !pend);

   // R9: a set event always lands, even beside a clear strobe
   generate
      if (SET_WINS) begin : g_set
         a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt |=> pend);
      end
   endgenerate

   // R6: the block right after a write-type command write raises nothing
   a_r6_skip_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_wr && !srst_set && cmd_class == 2'b01) && blk_start && !cmd_wr)
      |-> !set_evt);

   // R4: without either kind of event the flag holds
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_evt && !sts_rd && !cmd_wr && !srst_set) |=> $stable(pend));

   // R2: the active level accompanies the enable
   a_r2_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_oe |-> (irq_line == ACTIVE_HIGH));

   generate
      if (!OUT_REG) begin : g_comb
         // R3: gate closed means no drive
         a_r3_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
            (!dev_sel || nien) |-> !irq_oe);
         // R2: gate open and flag set means drive
         a_r2_drive: assert property (@(posedge clk) disable iff (!rst_n)
            (pend && dev_sel && !nien) |-> irq_oe);
      end else begin : g_reg
         a_r3_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
            (!dev_sel || nien) |=> !irq_oe);
      end
   endgenerate
endmodule

bind devirq_ctrl devirq_ctrl_chk #(
   .SET_WINS(SET_WINS), .OUT_REG(OUT_REG), .ACTIVE_HIGH(ACTIVE_HIGH)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wr    (cmd_wr),
   .cmd_class (cmd_class),
   .blk_start (blk_start),
   .srst_set  (srst_set),
   .sts_rd    (sts_rd),
   .dev_sel   (dev_sel),
   .nien      (nien),
   .set_evt   (set_evt),
   .pend      (pend),
   .irq_line  (irq_line),
   .irq_oe    (irq_oe)
);

// File: tb/test_devirq_ctrl.sv
module test_devirq_ctrl;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [1:0] cmd_class = 2'b00;
   logic       blk_start = 1'b0;
   logic       cmd_done = 1'b0;
   logic       srst_set = 1'b0;
   logic       sts_rd = 1'b0;
   logic       dev_sel = 1'b1;
   logic       nien = 1'b0;
   logic       irq_line;
   logic       irq_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   devirq_ctrl i_devirq_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_class(cmd_class),
      .blk_start(blk_start), .cmd_done(cmd_done), .srst_set(srst_set),
      .sts_rd(sts_rd), .dev_sel(dev_sel), .nien(nien),
      .irq_line(irq_line), .irq_oe(irq_oe)
   );

   task automatic chk(input string req, input logic exp_oe);
      n_chk++;
      if (irq_oe !== exp_oe || (irq_oe === 1'b1 && irq_line !== 1'b1)) begin
         n_bad++;
         $display("FAIL %s: oe=%b line=%b, expected oe=%b line=1 when driven",
                  req, irq_oe, irq_line, exp_oe);
      end
   endtask

   // Strobes rise just after an edge and fall after the next one.
   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic pulse_blk();  blk_start = 1; tick(); blk_start = 0; endtask
   task automatic pulse_done(); cmd_done = 1;  tick(); cmd_done = 0;  endtask
   task automatic pulse_rd();   sts_rd = 1;    tick(); sts_rd = 0;    endtask
   task automatic pulse_srst(); srst_set = 1;  tick(); srst_set = 0;  endtask
   task automatic write_cmd(input logic [1:0] c);
      cmd_class = c; cmd_wr = 1; tick(); cmd_wr = 0;
   endtask

   task automatic t_reset();
      chk("R1 during reset", 1'b0);
      rst_n = 1; tick();
      chk("R1 after reset", 1'b0);
      write_cmd(2'b00); pulse_blk();
      rst_n = 0; #1;
      chk("R1 reset drops pending", 1'b0);
      tick(); rst_n = 1; tick();
      chk("R1 stays clear", 1'b0);
   endtask

   task automatic t_pio_read();
      write_cmd(2'b00);
      pulse_blk(); chk("R5 first block", 1'b1);
      pulse_rd();  chk("R4 status read clears", 1'b0);
      pulse_blk(); chk("R5 second block", 1'b1);
      pulse_rd();
   endtask

   task automatic t_gating();
      write_cmd(2'b00); pulse_blk();
      dev_sel = 0; #1; chk("R3 deselected", 1'b0);
      dev_sel = 1; nien = 1; #1; chk("R3 nien set", 1'b0);
      tick(); chk("R3 still gated", 1'b0);
      nien = 0; #1; chk("R2 pending retained", 1'b1);
      pulse_rd();
   endtask

   task automatic t_pio_write();
      write_cmd(2'b01);
      pulse_blk(); chk("R6 first block skipped", 1'b0);
      pulse_blk(); chk("R6 second block raises", 1'b1);
      pulse_rd();
      pulse_blk(); chk("R6 third block raises", 1'b1);
      pulse_rd();
   endtask

   task automatic t_dma();
      write_cmd(2'b10);
      pulse_blk();  chk("R7 block ignored", 1'b0);
      pulse_done(); chk("R7 completion raises", 1'b1);
      pulse_rd();
      pulse_done(); chk("R7 only once", 1'b0);
   endtask

   task automatic t_nodata();
      write_cmd(2'b11);
      pulse_done(); chk("R8 completion raises", 1'b1);
      write_cmd(2'b00); chk("R4 command write clears", 1'b0);
   endtask

   task automatic t_collision();
      write_cmd(2'b00);
      blk_start = 1; sts_rd = 1; tick(); blk_start = 0; sts_rd = 0;
      chk("R9 set beats status read", 1'b1);
      pulse_rd();
   endtask

   task automatic t_srst();
      write_cmd(2'b00); pulse_blk();
      pulse_srst(); chk("R4 soft reset clears", 1'b0);
      pulse_blk();  chk("R10 block after soft reset", 1'b0);
      pulse_done(); chk("R10 done after soft reset", 1'b0);
   endtask

   task automatic t_pio_done();
      write_cmd(2'b00);
      pulse_done(); chk("R11 pio done silent", 1'b0);
      pulse_blk();  chk("R11 command ended", 1'b0);
   endtask

   initial begin
      tick(); tick();
      t_reset();
      t_pio_read();
      t_gating();
      t_pio_write();
      t_dma();
      t_nodata();
      t_collision();
      t_srst();
      t_pio_done();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule